// File: doc/BRIEF.md
# Three-Slot Decode Steering Unit

This block sits between a fetch path and the decoders of an in-order front end. The fetch path writes up to four delimited instruction entries per cycle (a 16-byte fetch packet) into an internal circular instruction buffer. Each entry carries a payload and a class field that gives how many micro-ops it expands to. Each cycle the block presents up to three buffered instructions, oldest first, to three decoder slots. Slot 0 is general. Slots 1 and 2 are restricted and take only instructions that expand to exactly one micro-op.

Instructions are removed from the buffer as they finish steering, and the micro-ops go on to a centralized reservation-station interface. A complex instruction found behind the head of the group ends that group. It then leads the next cycle's group in slot 0. There it produces its micro-ops one per cycle while the restricted slots stay idle. A full signal from the reservation station freezes the whole unit, and a flush empties it.

Top module: `decode_steer`

## Requirements
- R1: While reset is held, no slot is valid, `deq_count` is 0 and `fetch_ready` is 1.
- R2: When `fetch_valid` and `fetch_ready` are both high and `flush` is low, entries 0 to `fetch_cnt`-1 of `fetch_data` are appended to the buffer with entry 0 first. Entry i occupies bits [i*18 +: 18], its payload is bits [15:0] of the entry and its class is bits [17:16]. The entries can be steered from the next cycle on, in program order.
- R3: Slot 0 accepts the oldest buffered instruction of any class. A class-0 (single micro-op) instruction in slot 0 shows uop index 0 and is dequeued that cycle.
- R4: Slot k (k = 1, 2) is valid only when slots 0 to k-1 are valid, the head instruction is class 0, and buffer position k holds a class-0 instruction. Up to three simple instructions issue per cycle, in order.
- R5: An instruction with nonzero class at buffer position 1 or 2 ends the group at that position. It appears in slot 0 on the next non-stalled cycle.
- R6: An instruction of class c > 0 at the head produces c+1 micro-ops in slot 0 over consecutive non-stalled cycles, with uop indices 0 to c. Slots 1 and 2 are idle during those cycles. The instruction is dequeued in the cycle of its last micro-op.
- R7: While `rs_full` is high, no slot is valid, `deq_count` is 0, and the buffer contents and any micro-op sequence in progress are held.
- R8: `flush` makes every slot invalid in that cycle, drops any fetch write in that cycle, empties the buffer and cancels any micro-op sequence in progress.
- R9: `deq_count` (0 to 3) equals the number of contiguous valid slots, starting at slot 0, whose instructions finish this cycle.
- R10: `fetch_ready` is 1 exactly when the buffer (16 entries) has room for four more entries. A fetch write offered while it is 0 is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Empty the buffer and cancel the sequence |
| fetch_valid | input | 1 | Fetch packet offered |
| fetch_cnt | input | 3 | Number of entries in the packet (0 to 4) |
| fetch_data | input | 72 | Four 18-bit entries: {class[1:0], payload[15:0]} |
| fetch_ready | output | 1 | Buffer can take a full packet |
| rs_full | input | 1 | Reservation station cannot take micro-ops |
| slot_valid | output | 3 | Per-slot micro-op valid |
| slot_payload | output | 48 | Per-slot payload, slot k at [k*16 +: 16] |
| slot_uop | output | 6 | Per-slot micro-op index, slot k at [k*2 +: 2] |
| deq_count | output | 2 | Instructions dequeued this cycle |

## Verification
Every combination of classes in the first three buffer positions is loaded behind a simple fourth entry. This separates a full three-wide group, a group cut at position 1 or 2, and a multi-cycle head sequence of each length. Packets of zero to four entries check append order and partial writes. A long stretch of random fetch, stall and flush traffic mixes stalls into running sequences, which shows whether the sequence index and buffer are truly held. Directed cases flush in the middle of a sequence and fill the buffer until the ready signal drops, so that a write offered while not ready can be seen to vanish.

// File: rtl/steer_pkg.sv
`timescale 1ns/1ps
package steer_pkg;
  parameter int PAYLOAD_W = 16;
  parameter int CLASS_W   = 2;
  parameter int SLOTS     = 3;
  localparam int ENTRY_W  = PAYLOAD_W + CLASS_W;

  typedef struct packed {
    logic [CLASS_W-1:0]   extra;  // micro-ops minus one
    logic [PAYLOAD_W-1:0] body;
  } insn_t;
endpackage

// File: rtl/steer_buf.sv
`timescale 1ns/1ps
module steer_buf
  import steer_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int FETCH_W = 4,
  parameter int PEEK    = SLOTS,
  localparam int CNT_W  = $clog2(FETCH_W + 1),
  localparam int POP_W  = $clog2(PEEK + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    flush,
  input  logic                    wr_en,
  input  logic [CNT_W-1:0]        wr_cnt,
  input  insn_t [FETCH_W-1:0]     wr_data,
  input  logic [POP_W-1:0]        pop_n,
  output insn_t [PEEK-1:0]        peek,
  output logic [PEEK-1:0]         peek_ok,
  output logic                    space_ok
);
  localparam int AW = $clog2(DEPTH);
  localparam int NW = AW + 1;

  insn_t          mem [DEPTH];
  logic [AW-1:0]  rd_q, rd_d, wr_q, wr_d;
  logic [NW-1:0]  cnt_q, cnt_d;
  logic           wr_fire;
  logic [CNT_W-1:0] wr_n;

  assign space_ok = (int'(cnt_q) + FETCH_W) <= DEPTH;
  assign wr_fire  = wr_en && space_ok && !flush;
  assign wr_n     = wr_fire ? wr_cnt : '0;

  always_comb begin
    if (flush) begin
      rd_d  = '0;
      wr_d  = '0;
      cnt_d = '0;
    end else begin
      rd_d  = rd_q + AW'(pop_n);
      wr_d  = wr_q + AW'(wr_n);
      cnt_d = cnt_q + NW'(wr_n) - NW'(pop_n);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < FETCH_W; i++) begin
      if (wr_fire && (i < int'(wr_cnt))) begin
        mem[wr_q + AW'(i)] <= wr_data[i];
      end
    end
  end

  for (genvar k = 0; k < PEEK; k++) begin : g_peek
    assign peek[k]    = mem[rd_q + AW'(k)];
    assign peek_ok[k] = cnt_q > NW'(k);
  end

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pop_n) <= int'(cnt_q)); // R9
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) <= DEPTH); // R10
endmodule

// File: rtl/steer_pick.sv
`timescale 1ns/1ps
module steer_pick
  import steer_pkg::*;
#(
  localparam int POP_W = $clog2(SLOTS + 1)
) (
  input  logic [SLOTS-1:0][CLASS_W-1:0] cls,
  input  logic [SLOTS-1:0]              ok,
  input  logic [CLASS_W-1:0]            seq_idx,
  input  logic                          stall,
  output logic [SLOTS-1:0]              take,
  output logic [SLOTS-1:0][CLASS_W-1:0] uop,
  output logic [POP_W-1:0]              pop_n,
  output logic                          advance,
  output logic                          last
);
  logic head_cplx;
  int   acc;

  always_comb begin
    head_cplx = cls[0] != '0;
    last      = seq_idx == cls[0];
    take[0]   = !stall && ok[0];
    advance   = take[0] && head_cplx;
    uop[0]    = head_cplx ? seq_idx : '0;
    for (int k = 1; k < SLOTS; k++) begin
      take[k] = take[k-1] && !head_cplx && ok[k] && (cls[k] == '0);
      uop[k]  = '0;
    end
    acc = (take[0] && last) ? 1 : 0;
    for (int k = 1; k < SLOTS; k++) begin
      acc = acc + (take[k] ? 1 : 0);
    end
    pop_n = POP_W'(acc);
  end
endmodule

// File: rtl/steer_seq.sv
`timescale 1ns/1ps
module steer_seq
  import steer_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic               advance,
  input  logic               last,
  output logic [CLASS_W-1:0] idx_q
);
  logic [CLASS_W-1:0] idx_d;

  always_comb begin
    idx_d = idx_q;
    if (flush) begin
      idx_d = '0;
    end else if (advance) begin
      idx_d = last ? '0 : idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end
endmodule

// File: rtl/decode_steer.sv
`timescale 1ns/1ps
module decode_steer
  import steer_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int FETCH_W = 4,
  localparam int CNT_W  = $clog2(FETCH_W + 1),
  localparam int DQ_W   = $clog2(SLOTS + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush,
  input  logic                         fetch_valid,
  input  logic [CNT_W-1:0]             fetch_cnt,
  input  logic [FETCH_W*ENTRY_W-1:0]   fetch_data,
  output logic                         fetch_ready,
  input  logic                         rs_full,
  output logic [SLOTS-1:0]             slot_valid,
  output logic [SLOTS*PAYLOAD_W-1:0]   slot_payload,
  output logic [SLOTS*CLASS_W-1:0]     slot_uop,
  output logic [DQ_W-1:0]              deq_count
);
  insn_t [FETCH_W-1:0]           wr_vec;
  insn_t [SLOTS-1:0]             peek;
  logic  [SLOTS-1:0]             peek_ok;
  logic  [SLOTS-1:0][CLASS_W-1:0] peek_cls;
  logic  [SLOTS-1:0][CLASS_W-1:0] uop_v;
  logic  [CLASS_W-1:0]           seq_idx;
  logic  [DQ_W-1:0]              pop_n;
  logic                          advance, last, stall;

  assign wr_vec    = fetch_data;
  assign stall     = rs_full | flush;
  assign deq_count = pop_n;

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    assign peek_cls[k] = peek[k].extra;
    assign slot_payload[k*PAYLOAD_W +: PAYLOAD_W] = peek[k].body;
    assign slot_uop[k*CLASS_W +: CLASS_W]         = uop_v[k];
  end

  steer_buf #(.DEPTH(DEPTH), .FETCH_W(FETCH_W), .PEEK(SLOTS)) u_buf (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .wr_en(fetch_valid), .wr_cnt(fetch_cnt), .wr_data(wr_vec),
    .pop_n(pop_n), .peek(peek), .peek_ok(peek_ok), .space_ok(fetch_ready)
  );

  steer_pick u_pick (
    .cls(peek_cls), .ok(peek_ok), .seq_idx(seq_idx), .stall(stall),
    .take(slot_valid), .uop(uop_v), .pop_n(pop_n),
    .advance(advance), .last(last)
  );

  steer_seq u_seq (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .advance(advance), .last(last), .idx_q(seq_idx)
  );

  for (genvar k = 1; k < SLOTS; k++) begin : g_chk
    AST_CONTIG: assert property (@(posedge clk) disable iff (!rst_n)
      slot_valid[k] |-> slot_valid[k-1]); // R4
  end
  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rs_full |-> (slot_valid == '0 && deq_count == '0)); // R7
  AST_FULL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_full && !flush && !fetch_valid) |=> (peek_ok == $past(peek_ok))); // R7
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (slot_valid == '0)); // R8
  AST_SEQ_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_idx != '0) |-> peek_ok[0]); // R6
  AST_SEQ_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_idx != '0) |-> (peek[0].extra >= seq_idx)); // R6
  AST_DEQ_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(slot_valid) >= int'(deq_count)); // R9
endmodule

// File: tb/sim_decode_steer.sv
`timescale 1ns/1ps
module sim_decode_steer;
  localparam int DEPTH = 16;
  localparam int FW    = 4;
  localparam int EW    = 18;
  localparam int PW    = 16;

  logic          clk = 1'b0;
  logic          rst_n, flush, fetch_valid, rs_full, fetch_ready;
  logic [2:0]    fetch_cnt;
  logic [FW*EW-1:0] fetch_data;
  logic [2:0]    slot_valid;
  logic [3*PW-1:0] slot_payload;
  logic [5:0]    slot_uop;
  logic [1:0]    deq_count;

  int vecs = 0;
  int bad  = 0;
  bit done = 0;

  logic [EW-1:0] mq[$];
  int            mseq = 0;
  int            pay  = 1;
  logic [EW-1:0] bdat [FW];
  bit bfv, bfull, bflush;
  int bfc;

  always #10 clk = ~clk;

  decode_steer #(.DEPTH(DEPTH), .FETCH_W(FW)) u0 (
    .clk(clk), .rst_n(rst_n), .flush(flush), .fetch_valid(fetch_valid),
    .fetch_cnt(fetch_cnt), .fetch_data(fetch_data), .fetch_ready(fetch_ready),
    .rs_full(rs_full), .slot_valid(slot_valid), .slot_payload(slot_payload),
    .slot_uop(slot_uop), .deq_count(deq_count)
  );

  task automatic chk(string tag, int act, int exp);
    vecs++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle();
    bfv = 0; bfc = 0; bfull = 0; bflush = 0;
  endtask

  task automatic set_e(int i, int cls);
    bdat[i] = {2'(cls), 16'(pay)};
    pay++;
  endtask

  // One cycle: drive after the falling edge, check mid-low phase, model update.
  task automatic tick(string tag);
    int n;
    bit [2:0] ev;
    int eu0, ed, c0;
    int ep [3];
    bit er;
    flush = bflush; rs_full = bfull; fetch_valid = bfv; fetch_cnt = 3'(bfc);
    for (int i = 0; i < FW; i++) fetch_data[i*EW +: EW] = bdat[i];
    #5;
    n = mq.size(); ev = '0; eu0 = 0; ed = 0; c0 = 0;
    for (int k = 0; k < 3; k++) ep[k] = 0;
    er = (n + FW) <= DEPTH;
    if (!bflush && !bfull && n > 0) begin
      c0 = int'(mq[0][17:16]);
      ev[0] = 1'b1; ep[0] = int'(mq[0][15:0]);
      if (c0 != 0) begin
        eu0 = mseq;
        ed  = (mseq == c0) ? 1 : 0;
      end else begin
        ed = 1;
        for (int k = 1; k < 3; k++) begin
          if (k < n && ev[k-1] && mq[k][17:16] == 2'd0) begin
            ev[k] = 1'b1; ep[k] = int'(mq[k][15:0]); ed++;
          end
        end
      end
    end
    chk("R10 ready", int'(fetch_ready), int'(er));
    chk({tag, " valid"}, int'(slot_valid), int'(ev));
    chk("R9 deq", int'(deq_count), ed);
    for (int k = 0; k < 3; k++) begin
      if (ev[k]) begin
        chk({tag, " payload"}, int'(slot_payload[k*PW +: PW]), ep[k]);
        chk({tag, " uop"}, int'(slot_uop[k*2 +: 2]), (k == 0) ? eu0 : 0);
      end
    end
    if (bflush) begin
      mq.delete(); mseq = 0;
    end else begin
      if (ev[0] && c0 != 0) mseq = (ed == 1) ? 0 : mseq + 1;
      repeat (ed) void'(mq.pop_front());
      if (bfv && er) for (int i = 0; i < bfc; i++) mq.push_back(bdat[i]);
    end
    @(negedge clk);
  endtask

  task automatic drain(string tag);
    idle();
    for (int i = 0; i < 40 && mq.size() > 0; i++) tick(tag);
    tick(tag);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; flush = 0; fetch_valid = 0; rs_full = 0; fetch_cnt = '0;
    fetch_data = '0;
    for (int i = 0; i < FW; i++) bdat[i] = '0;
    idle();
    #25;
    chk("R1 valid", int'(slot_valid), 0);
    chk("R1 deq", int'(deq_count), 0);
    chk("R1 ready", int'(fetch_ready), 1);
    @(negedge clk);
    rst_n = 1'b1;

    // Exhaustive classes for the first three positions (R3 R4 R5 R6).
    for (int p = 0; p < 64; p++) begin
      int c [3];
      string tg;
      c[0] = p % 4; c[1] = (p / 4) % 4; c[2] = p / 16;
      tg = (c[0] != 0) ? "R6" : ((c[1] != 0 || c[2] != 0) ? "R5" : "R3 R4");
      idle(); bflush = 1; tick("R8");
      idle();
      for (int i = 0; i < 3; i++) set_e(i, c[i]);
      set_e(3, 0);
      bfv = 1; bfc = 4;
      tick(tg);
      drain(tg);
    end

    // Packet sizes 0..4 held behind a stall, then released (R2 R7).
    for (int n = 0; n <= 4; n++) begin
      idle(); bfull = 1;
      for (int i = 0; i < FW; i++) set_e(i, 0);
      bfv = 1; bfc = n;
      tick("R2 R7");
      idle(); bfull = 1; tick("R7");
      drain("R2");
    end

    // Random traffic with stalls and flushes (R7 R8 R6).
    for (int t = 0; t < 600; t++) begin
      idle();
      bfv = ($urandom % 2) == 1;
      bfc = $urandom % 5;
      for (int i = 0; i < FW; i++) set_e(i, (($urandom % 3) == 0) ? ($urandom % 4) : 0);
      bfull  = ($urandom % 4) == 0;
      bflush = ($urandom % 50) == 0;
      tick(bflush ? "R8" : (bfull ? "R7" : "R6 R4"));
    end
    drain("R6");

    // Flush in the middle of a four-uop sequence (R8).
    idle(); set_e(0, 3); set_e(1, 0); bfv = 1; bfc = 2; tick("R6");
    idle(); tick("R6"); tick("R6");
    bflush = 1; bfv = 1; bfc = 1; set_e(0, 0); tick("R8");
    idle(); tick("R8"); tick("R8");

    // Fill until ready drops; the extra packet is dropped (R10).
    idle(); bfull = 1;
    for (int r = 0; r < 5; r++) begin
      for (int i = 0; i < FW; i++) set_e(i, 0);
      bfv = 1; bfc = 4;
      tick("R10");
    end
    drain("R10");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule